// File: doc/BRIEF.md
# Multi-Context Banked Register File

This block stores the working registers of a processor that keeps a full register set for each of sixteen hardware contexts. Every context owns eight 16-bit registers, indexed 0 to 7 as A, B, X, Y, Z, S, C (control word) and P (program counter base). The execution side reads and writes the registers of the running context through a word port with per-byte write enables. A separate byte-wide window maps every register of every context into a 256-byte address space, so that supervisory code can inspect or prepare any context with ordinary loads and stores.

The block also holds the running context number. A hardware interrupt request moves execution to the requested context and records the outgoing context number in the previous-level field of the incoming context's control word. A return strobe moves execution back to the context named in that field. The control word carries the previous level in bits 15-12, four unused bits 11-8, the zero, minus, fault and link flags in bits 7, 6, 5 and 4, and a page map number in bits 3-0. This block only stores these bits; it does not interpret the flags or the map.

Top module: `rfctx_bank`

## Requirements
- R1: While rst_n is low at a clock edge, every register of every context becomes 0x0000, cur_ctx becomes 0 and win_rdata becomes 0x00.
- R2: When cpu_wr_en is high, cpu_wr_mask bit 1 writes cpu_wr_data[15:8] and bit 0 writes cpu_wr_data[7:0] into register cpu_wr_idx of the current context; an unselected byte keeps its value. cpu_rd_data shows register cpu_rd_idx of the current context without a clock delay.
- R3: Window address bits 7-4 select the context, bits 3-1 the register index (A=0, B=1, X=2, Y=3, Z=4, S=5, C=6, P=7) and bit 0 the byte: 0 is bits 15-8, 1 is bits 7-0.
- R4: win_rdata presents, one clock after win_addr is sampled, the addressed byte as it stood before any write taking effect at that same edge.
- R5: A window write to a context other than the current one updates the addressed byte of any register, C and P included.
- R6: A window write to the current context updates A, B, X, Y, Z and S; a window write to the current context's C (index 6) or P (index 7) is dropped.
- R7: Bits 11-8 of every control word (index 6) always read as zero; any write to them is discarded.
- R8: When irq_req is high, cur_ctx takes irq_ctx at the edge, and bits 15-12 of the control word of context irq_ctx take the outgoing context number at that same edge, overriding any other write to those bits; its other bits are kept or written normally.
- R9: When rti is high and irq_req is low, cur_ctx takes bits 15-12 of the current context's control word as they stood before the edge; when both are high, the interrupt wins.
- R10: When a CPU write (nonzero mask) and a window write address the same register of the current context in one cycle, the window write is dropped whole; writes to different registers in one cycle both take effect.
- R11: CPU writes, and the own-context rule of R6, in a cycle that also switches context apply to the context that was current before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd_idx | input | 3 | Register index for the CPU read port |
| cpu_rd_data | output | 16 | Current-context register selected by cpu_rd_idx |
| cpu_wr_en | input | 1 | CPU write request |
| cpu_wr_idx | input | 3 | Register index for the CPU write |
| cpu_wr_mask | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| cpu_wr_data | input | 16 | CPU write data |
| win_addr | input | 8 | Window byte address |
| win_wr_en | input | 1 | Window write request |
| win_wdata | input | 8 | Window write byte |
| win_rdata | output | 8 | Window read byte, one cycle after the address |
| irq_req | input | 1 | Interrupt context switch request |
| irq_ctx | input | 4 | Context to switch to on an interrupt |
| rti | input | 1 | Return-from-interrupt strobe |
| cur_ctx | output | 4 | Currently running context |

## Verification
The assertions take for granted that every input carries a defined value at each rising edge and that reset is held long enough to cover at least one edge; they place no restriction on simultaneous interrupt, return, CPU and window activity. The stimulus keeps all inputs driven shortly after each rising edge, holds irq_req and rti low during reset, and deliberately lets interrupts coincide with returns, CPU writes and window writes aimed at the running context. Random window addresses are biased half the time toward the running context so that the dropped-write and collision rules are exercised often.

// File: rtl/rfctx_pkg.sv
// Package: shared sizes, field positions and types for the banked register file.
// Assumes a 16-bit register word made of two bytes and a context number that
// fits exactly into the top bits of the control word.
package rfctx_pkg;
    localparam int CTX_N    = 16;
    localparam int REG_N    = 8;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int CTX_W    = $clog2(CTX_N);
    localparam int IDX_W    = $clog2(REG_N);
    localparam int WIN_AW   = CTX_W + IDX_W + 1;
    localparam int SLOT_N   = CTX_N * REG_N;
    localparam int CTRL_IDX = 6;
    localparam int PCB_IDX  = 7;
    localparam int PREV_LO  = WORD_W - CTX_W;
    localparam int RSV_HI   = PREV_LO - 1;
    localparam int RSV_LO   = 8;

    typedef logic [CTX_W-1:0]  ctx_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // True for the indices that the running context may not alter through the window.
    function automatic logic idx_guarded(idx_t i);
        return (i == idx_t'(CTRL_IDX)) || (i == idx_t'(PCB_IDX));
    endfunction
endpackage

// File: rtl/rfctx_switch.sv
// Module: holds the running context number and produces the interrupt save.
// Assumes ret_ctx is the previous-level field of the running context's control
// word as stored before the edge. Interrupt requests outrank return strobes.
module rfctx_switch
    import rfctx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  ctx_t irq_ctx,
    input  logic rti,
    input  ctx_t ret_ctx,
    output ctx_t cur_ctx,
    output logic save_en,
    output ctx_t save_dst,
    output ctx_t save_val
);
    ctx_t cur_q;

    // Advance the running context on interrupt or return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (irq_req) begin
            cur_q <= irq_ctx;
        end else if (rti) begin
            cur_q <= ret_ctx;
        end
    end

    // The outgoing context is recorded in the incoming context's control word.
    always_comb begin
        save_en  = irq_req;
        save_dst = irq_ctx;
        save_val = cur_q;
    end

    assign cur_ctx = cur_q;
endmodule

// File: rtl/rfctx_window.sv
// Module: decodes the byte window, filters writes and registers read data.
// Assumes sel_word is the stored word addressed by win_addr[WIN_AW-1:1] before
// the edge. Drops writes to the running context's guarded registers and writes
// that collide with a CPU write to the same register.
module rfctx_window
    import rfctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIN_AW-1:0] win_addr,
    input  logic              win_wr_en,
    input  byte_t             win_wdata,
    input  ctx_t              cur_ctx,
    input  logic              cpu_wr_en,
    input  idx_t              cpu_wr_idx,
    input  logic [1:0]        cpu_wr_mask,
    input  word_t             sel_word,
    output ctx_t              w_ctx,
    output idx_t              w_idx,
    output logic [1:0]        w_be,
    output byte_t             w_byte,
    output byte_t             win_rdata
);
    logic  lo_sel;
    logic  own_ctx;
    logic  blocked_own;
    logic  clash_cpu;
    logic  accept;
    byte_t rd_q;

    // Split the window address into context, register and byte.
    always_comb begin
        w_ctx  = win_addr[WIN_AW-1 -: CTX_W];
        w_idx  = win_addr[IDX_W:1];
        lo_sel = win_addr[0];
    end

    // Decide whether a window write may proceed and which byte it hits.
    always_comb begin
        own_ctx     = (w_ctx == cur_ctx);
        blocked_own = own_ctx && idx_guarded(w_idx);
        clash_cpu   = cpu_wr_en && (cpu_wr_mask != 2'b00) && own_ctx && (cpu_wr_idx == w_idx);
        accept      = win_wr_en && !blocked_own && !clash_cpu;
        w_be        = accept ? (lo_sel ? 2'b01 : 2'b10) : 2'b00;
        w_byte      = win_wdata;
    end

    // Capture the addressed byte for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= lo_sel ? sel_word[BYTE_W-1:0] : sel_word[WORD_W-1:BYTE_W];
        end
    end

    assign win_rdata = rd_q;
endmodule

// File: rtl/rfctx_cell.sv
// Module: one 16-bit register with separate CPU and window byte enables and an
// interrupt save into the top field. Assumes the caller never enables a CPU and
// a window write on the same byte; if it does, the CPU byte wins.
// IS_CTRL selects the control-word variant whose reserved bits stay zero.
module rfctx_cell
    import rfctx_pkg::*;
#(
    parameter bit IS_CTRL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cpu_be,
    input  word_t      cpu_d,
    input  logic [1:0] win_be,
    input  byte_t      win_d,
    input  logic       save_en,
    input  ctx_t       save_val,
    output word_t      q
);
    word_t q_r;
    word_t nxt;
    word_t clean;

    // Merge window bytes, then CPU bytes, then the interrupt save.
    always_comb begin
        nxt = q_r;
        if (win_be[1]) nxt[WORD_W-1:BYTE_W] = win_d;
        if (win_be[0]) nxt[BYTE_W-1:0]      = win_d;
        if (cpu_be[1]) nxt[WORD_W-1:BYTE_W] = cpu_d[WORD_W-1:BYTE_W];
        if (cpu_be[0]) nxt[BYTE_W-1:0]      = cpu_d[BYTE_W-1:0];
        if (save_en)   nxt[WORD_W-1:PREV_LO] = save_val;
    end

    generate
        if (IS_CTRL) begin : g_ctrl
            assign clean = {nxt[WORD_W-1:PREV_LO], {(RSV_HI-RSV_LO+1){1'b0}}, nxt[RSV_LO-1:0]};
        end else begin : g_plain
            assign clean = nxt;
        end
    endgenerate

    // Store the merged word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else begin
            q_r <= clean;
        end
    end

    assign q = q_r;
endmodule

// File: rtl/rfctx_bank.sv
// Module: top of the banked register file. Sixteen contexts of eight words,
// a CPU port on the running context and a byte window onto all contexts.
// Assumes all inputs are defined at each edge; all writes in a cycle use the
// context that is current before the edge.
module rfctx_bank
    import rfctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cpu_rd_idx,
    output logic [WORD_W-1:0] cpu_rd_data,
    input  logic              cpu_wr_en,
    input  logic [IDX_W-1:0]  cpu_wr_idx,
    input  logic [1:0]        cpu_wr_mask,
    input  logic [WORD_W-1:0] cpu_wr_data,
    input  logic [WIN_AW-1:0] win_addr,
    input  logic              win_wr_en,
    input  logic [BYTE_W-1:0] win_wdata,
    output logic [BYTE_W-1:0] win_rdata,
    input  logic              irq_req,
    input  logic [CTX_W-1:0]  irq_ctx,
    input  logic              rti,
    output logic [CTX_W-1:0]  cur_ctx
);
    word_t      cell_q [SLOT_N];
    ctx_t       ctx_now;
    word_t      ctrl_word;
    ctx_t       ret_ctx;
    word_t      sel_word;
    ctx_t       w_ctx;
    idx_t       w_idx;
    logic [1:0] w_be;
    byte_t      w_byte;
    logic       save_en;
    ctx_t       save_dst;
    ctx_t       save_val;

    // Read paths: running control word, CPU read word, window word.
    always_comb begin
        ctrl_word   = cell_q[{ctx_now, idx_t'(CTRL_IDX)}];
        ret_ctx     = ctrl_word[WORD_W-1:PREV_LO];
        cpu_rd_data = cell_q[{ctx_now, cpu_rd_idx}];
        sel_word    = cell_q[win_addr[WIN_AW-1:1]];
    end

    rfctx_switch u_switch (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .irq_ctx  (irq_ctx),
        .rti      (rti),
        .ret_ctx  (ret_ctx),
        .cur_ctx  (ctx_now),
        .save_en  (save_en),
        .save_dst (save_dst),
        .save_val (save_val)
    );

    rfctx_window u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_addr    (win_addr),
        .win_wr_en   (win_wr_en),
        .win_wdata   (win_wdata),
        .cur_ctx     (ctx_now),
        .cpu_wr_en   (cpu_wr_en),
        .cpu_wr_idx  (cpu_wr_idx),
        .cpu_wr_mask (cpu_wr_mask),
        .sel_word    (sel_word),
        .w_ctx       (w_ctx),
        .w_idx       (w_idx),
        .w_be        (w_be),
        .w_byte      (w_byte),
        .win_rdata   (win_rdata)
    );

    generate
        for (genvar c = 0; c < CTX_N; c++) begin : g_ctx
            for (genvar r = 0; r < REG_N; r++) begin : g_reg
                localparam bit IS_CTRL = (r == CTRL_IDX);
                logic [1:0] cpu_be;
                logic [1:0] win_be;
                logic       save_hit;

                // Route each write source to this register only.
                assign cpu_be   = (cpu_wr_en && ctx_now == ctx_t'(c) && cpu_wr_idx == idx_t'(r))
                                  ? cpu_wr_mask : 2'b00;
                assign win_be   = (w_ctx == ctx_t'(c) && w_idx == idx_t'(r)) ? w_be : 2'b00;
                assign save_hit = IS_CTRL && save_en && (save_dst == ctx_t'(c));

                rfctx_cell #(.IS_CTRL(IS_CTRL)) u_cell (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .cpu_be   (cpu_be),
                    .cpu_d    (cpu_wr_data),
                    .win_be   (win_be),
                    .win_d    (w_byte),
                    .save_en  (save_hit),
                    .save_val (save_val),
                    .q        (cell_q[c*REG_N+r])
                );
            end
        end
    endgenerate

    assign cur_ctx = ctx_now;
endmodule

// File: rtl/rfctx_bank_chk.sv
// Module: property checker for rfctx_bank, attached by bind. Observes the
// running context, the running control word and the request inputs.
module rfctx_bank_chk
    import rfctx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CTX_W-1:0]  cur_ctx,
    input logic              irq_req,
    input logic [CTX_W-1:0]  irq_ctx,
    input logic              rti,
    input logic [WIN_AW-1:0] win_addr,
    input logic              win_wr_en,
    input logic              cpu_wr_en,
    input logic [WORD_W-1:0] ctrl_word
);
    // R1: reset leaves context 0 running.
    p_reset_ctx_r1: assert property (@(posedge clk) !rst_n |=> cur_ctx == '0);

    // R8: an interrupt switches to the requested context.
    p_irq_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> cur_ctx == $past(irq_ctx));

    // R8: the incoming control word records the outgoing context.
    p_irq_saves_prev_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> ctrl_word[WORD_W-1:PREV_LO] == $past(cur_ctx));

    // R9: a lone return goes to the saved previous level.
    p_rti_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && !irq_req) |=> cur_ctx == $past(ctrl_word[WORD_W-1:PREV_LO]));

    // R7: reserved control bits stay zero.
    p_rsv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[RSV_HI:RSV_LO] == '0);

    // R6: the window cannot alter the running context's control word.
    p_own_ctrl_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr_en && win_addr[WIN_AW-1 -: CTX_W] == cur_ctx
         && win_addr[IDX_W:1] == idx_t'(CTRL_IDX) && !cpu_wr_en && !irq_req && !rti)
        |=> $stable(ctrl_word));
endmodule

bind rfctx_bank rfctx_bank_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_ctx   (cur_ctx),
    .irq_req   (irq_req),
    .irq_ctx   (irq_ctx),
    .rti       (rti),
    .win_addr  (win_addr),
    .win_wr_en (win_wr_en),
    .cpu_wr_en (cpu_wr_en),
    .ctrl_word (ctrl_word)
);

// File: tb/rfctx_bank_tb_top.sv
// Bench: directed corner cases then seeded random traffic, all compared with a
// bench-side model of the register file written from the requirements.
module rfctx_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cpu_rd_idx = '0;
    logic [15:0] cpu_rd_data;
    logic        cpu_wr_en = 1'b0;
    logic [2:0]  cpu_wr_idx = '0;
    logic [1:0]  cpu_wr_mask = '0;
    logic [15:0] cpu_wr_data = '0;
    logic [7:0]  win_addr = '0;
    logic        win_wr_en = 1'b0;
    logic [7:0]  win_wdata = '0;
    logic [7:0]  win_rdata;
    logic        irq_req = 1'b0;
    logic [3:0]  irq_ctx = '0;
    logic        rti = 1'b0;
    logic [3:0]  cur_ctx;

    logic [15:0] m_bank [16][8];
    logic [3:0]  m_ctx;
    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    rfctx_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_rd_idx(cpu_rd_idx), .cpu_rd_data(cpu_rd_data),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_idx(cpu_wr_idx),
        .cpu_wr_mask(cpu_wr_mask), .cpu_wr_data(cpu_wr_data),
        .win_addr(win_addr), .win_wr_en(win_wr_en),
        .win_wdata(win_wdata), .win_rdata(win_rdata),
        .irq_req(irq_req), .irq_ctx(irq_ctx), .rti(rti), .cur_ctx(cur_ctx)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cpu_wr_en = 1'b0; cpu_wr_mask = 2'b00; win_wr_en = 1'b0;
        irq_req = 1'b0; rti = 1'b0;
    endtask

    // Model one clock edge from the requirements; returns the expected read byte.
    function automatic logic [7:0] model_edge();
        logic [3:0]  old = m_ctx;
        logic [15:0] pre_c = m_bank[old][6];
        logic [3:0]  wc = win_addr[7:4];
        logic [2:0]  wi = win_addr[3:1];
        logic [7:0]  rb = win_addr[0] ? m_bank[wc][wi][7:0] : m_bank[wc][wi][15:8];
        if (win_wr_en && !(wc == old && wi >= 3'd6)
            && !(cpu_wr_en && cpu_wr_mask != 2'b00 && wc == old && wi == cpu_wr_idx)) begin
            if (win_addr[0]) m_bank[wc][wi][7:0]  = win_wdata;
            else             m_bank[wc][wi][15:8] = win_wdata;
        end
        if (cpu_wr_en) begin
            if (cpu_wr_mask[1]) m_bank[old][cpu_wr_idx][15:8] = cpu_wr_data[15:8];
            if (cpu_wr_mask[0]) m_bank[old][cpu_wr_idx][7:0]  = cpu_wr_data[7:0];
        end
        if (irq_req) begin
            m_bank[irq_ctx][6][15:12] = old;
            m_ctx = irq_ctx;
        end else if (rti) begin
            m_ctx = pre_c[15:12];
        end
        for (int c = 0; c < 16; c++) m_bank[c][6][11:8] = 4'h0;
        return rb;
    endfunction

    // Apply the driven inputs for one edge and compare outputs with the model.
    task automatic step(input string tag);
        logic [7:0] exp_rb;
        exp_rb = model_edge();
        @(posedge clk);
        #1;
        check({tag, " win_rdata"}, 32'(win_rdata), 32'(exp_rb));
        check({tag, " cur_ctx"}, 32'(cur_ctx), 32'(m_ctx));
        check({tag, " cpu_rd_data"}, 32'(cpu_rd_data), 32'(m_bank[m_ctx][cpu_rd_idx]));
    endtask

    task automatic cpu_wr(input logic [2:0] idx, input logic [1:0] mask, input logic [15:0] d);
        cpu_wr_en = 1'b1; cpu_wr_idx = idx; cpu_wr_mask = mask; cpu_wr_data = d;
    endtask

    task automatic win_wr(input logic [7:0] a, input logic [7:0] d);
        win_wr_en = 1'b1; win_addr = a; win_wdata = d;
    endtask

    // Window read: address this cycle, byte checked after the next edge.
    task automatic win_rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
        idle(); win_addr = a;
        step(tag);
        check({tag, " directed byte"}, 32'(win_rdata), 32'(exp));
    endtask

    initial begin
        for (int c = 0; c < 16; c++)
            for (int r = 0; r < 8; r++) m_bank[c][r] = 16'h0000;
        m_ctx = 4'h0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1: state after reset
        check("R1 cur_ctx", 32'(cur_ctx), 32'h0);
        check("R1 win_rdata", 32'(win_rdata), 32'h0);
        check("R1 cpu_rd_data", 32'(cpu_rd_data), 32'h0);
        rst_n = 1'b1;

        // R2: word then byte writes on the CPU port
        idle(); cpu_wr(3'd0, 2'b11, 16'h1234); step("R2");
        check("R2 word", 32'(cpu_rd_data), 32'h1234);
        idle(); cpu_wr(3'd0, 2'b10, 16'hAB99); step("R2");
        check("R2 upper byte", 32'(cpu_rd_data), 32'hAB34);
        idle(); cpu_wr(3'd0, 2'b01, 16'h77CD); step("R2");
        check("R2 lower byte", 32'(cpu_rd_data), 32'hABCD);

        // R3 and R4: byte order and read latency
        win_rd("R3", 8'h00, 8'hAB);
        win_rd("R3", 8'h01, 8'hCD);
        idle(); win_wr(8'h37, 8'h5A); step("R3");
        win_rd("R3", 8'h37, 8'h5A);
        win_rd("R3", 8'h36, 8'h00);
        idle(); win_wr(8'h00, 8'h11); step("R4");
        check("R4 read returns pre-write byte", 32'(win_rdata), 32'hAB);

        // R5: other context C and P through the window
        idle(); win_wr(8'h2E, 8'h77); step("R5");
        win_rd("R5", 8'h2E, 8'h77);
        idle(); win_wr(8'h2D, 8'h3F); step("R5");
        win_rd("R5", 8'h2D, 8'h3F);

        // R6: own P and C dropped, own S accepted
        idle(); win_wr(8'h0E, 8'h99); step("R6");
        win_rd("R6", 8'h0E, 8'h00);
        idle(); win_wr(8'h0D, 8'h55); step("R6");
        win_rd("R6", 8'h0D, 8'h00);
        idle(); win_wr(8'h0A, 8'h42); cpu_rd_idx = 3'd5; step("R6");
        check("R6 own S", 32'(cpu_rd_data), 32'h4200);

        // R7: reserved control bits
        idle(); cpu_wr(3'd6, 2'b11, 16'hFFFF); cpu_rd_idx = 3'd6; step("R7");
        check("R7 cpu write", 32'(cpu_rd_data), 32'hF0FF);
        idle(); win_wr(8'h2C, 8'hFF); step("R7");
        win_rd("R7", 8'h2C, 8'hF0);

        // R10: collision on one register, and no collision on two
        idle(); cpu_wr(3'd0, 2'b11, 16'h1111); win_wr(8'h00, 8'hEE); cpu_rd_idx = 3'd0; step("R10");
        check("R10 cpu wins", 32'(cpu_rd_data), 32'h1111);
        idle(); cpu_wr(3'd0, 2'b11, 16'h2222); win_wr(8'h03, 8'h55); step("R10");
        win_rd("R10", 8'h03, 8'h55);

        // R8 and R11: switch to 2 while writing A of context 0
        idle(); irq_req = 1'b1; irq_ctx = 4'd2; cpu_wr(3'd0, 2'b11, 16'h7777); cpu_rd_idx = 3'd6; step("R8");
        check("R8 cur_ctx", 32'(cur_ctx), 32'h2);
        check("R8 saved prev", 32'(cpu_rd_data), 32'h003F);
        win_rd("R11", 8'h00, 8'h77);
        // R11: own-context guard follows the pre-edge context in a switch cycle
        idle(); irq_req = 1'b1; irq_ctx = 4'd9; win_wr(8'h2F, 8'h66); step("R11");
        win_rd("R11", 8'h2F, 8'h00);

        // R9: returns, and interrupt beating a return
        idle(); rti = 1'b1; step("R9");
        check("R9 return to 2", 32'(cur_ctx), 32'h2);
        idle(); rti = 1'b1; irq_req = 1'b1; irq_ctx = 4'd5; step("R9");
        check("R9 irq wins", 32'(cur_ctx), 32'h5);
        idle(); rti = 1'b1; step("R9");
        check("R9 back to 2", 32'(cur_ctx), 32'h2);

        // R3: seeded random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            idle();
            cpu_rd_idx  = 3'($urandom);
            cpu_wr_en   = ($urandom % 10) < 4;
            cpu_wr_idx  = 3'($urandom);
            cpu_wr_mask = 2'($urandom);
            cpu_wr_data = 16'($urandom);
            win_wr_en   = ($urandom % 2) == 0;
            win_addr    = 8'($urandom);
            if ($urandom % 2 == 0) win_addr[7:4] = m_ctx;
            win_wdata   = 8'($urandom);
            irq_req     = ($urandom % 20) == 0;
            irq_ctx     = 4'($urandom);
            rti         = ($urandom % 16) == 0;
            step("R3 random");
        end
        idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule